// File: doc/BRIEF.md
# Residue adder for moduli of the form 2^N - 2^K - 1

This block adds two residues modulo m = 2^N - 2^K - 1 in pure combinational logic. Its callers are the arithmetic channels of a residue number system datapath, where every operand already lies in the range 0 to m-1. The block returns (A+B) mod m in the same N-bit width.

The block adds the correction constant T = 2^N - m = 2^K + 1 in a pre-processing stage. This stage is a carry-save row that has only two constant-one positions, bit 0 and bit K. It leaves ordinary generate/propagate pairs for a single Sklansky prefix network. That network is split at bit K into a low segment and a high segment, and the two are stitched with one group operation.

The carry-out of A+B+T decides which result is used. The carries of plain A+B are not produced by a second carry network. They are recovered by correcting the A+B+T result twice: first by removing 1 at bit 0, then by removing 2^K. The last stage forms each sum bit by XOR of a partial-sum bit with the selected real carry.

Top module: `rns_mod_adder`

## Requirements
- R1: For every A < m and B < m, sum_o equals (A+B) mod m, where m = 2^N - 2^K - 1 (239 for the default N=8, K=4).
- R2: For legal inputs, sum_o is always strictly below m.
- R3: When A+B < m, sum_o equals A+B with no correction; 0+0 gives 0.
- R4: When A+B >= m, sum_o equals A+B-m. This includes sums at or above 2^N (238+238 gives 237 at the default size).
- R5: At the wrap boundary, A+B = m-1 gives m-1 and A+B = m gives 0.
- R6: Swapping the two operands leaves sum_o unchanged.
- R7: The result stays correct for other sizes with 1 <= K <= N-2, for example N=11, K=3 (m=2039).
- R8: The wrapped result comes from one prefix network over A+B+T. That result is right when carries cross the segment boundary at bit K (17+223 gives 1 at the default size).
- R9: The unwrapped result comes from the two-step correction of A+B+T. That result is right under long carry runs in A+B (16+222 gives 238, 15+15 gives 30).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N | First residue operand, below m |
| b_i | input | N | Second residue operand, below m |
| sum_o | output | N | (a_i + b_i) mod m |

## Verification
The riskiest corner is the boundary pair of sums m-1 and m. A wrong selection condition either leaves m itself on the output or wraps m-1 down to 0. The bench also targets sums that reach or exceed 2^N. A design that drops the carry-save carry-out of the top bit would return A+B-2^N there instead of A+B-m. Operand pairs whose carries ripple through bit K expose a bad stitch between the segments or a mishandled constant at bit K. Sums with long runs of ones stress the borrow chains of the correction, which would otherwise give wrong unwrapped results. An exhaustive sweep at the default size and a randomized sweep at a second size catch errors that depend on the parameters.

// File: rtl/modadd_pkg.sv
package modadd_pkg;
  // Prefix operator: (g_hi,p_hi) o (g_lo,p_lo) -> {G,P}
  function automatic logic [1:0] gp_merge(input logic g_hi, input logic p_hi,
                                          input logic g_lo, input logic p_lo);
    return {g_hi | (p_hi & g_lo), p_hi & p_lo};
  endfunction
endpackage

// File: rtl/modadd_pre.sv
module modadd_pre #(
  parameter int unsigned N = 8,
  parameter int unsigned K = 4
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  output logic [N-1:0] g_o,
  output logic [N-1:0] q_o,
  output logic [N-1:0] p_o,
  output logic         cn_o
);
  logic [N-1:0] h;
  logic [N:0]   cv;

  assign cv[0] = 1'b0;
  assign p_o   = a_i ^ b_i;
  assign cn_o  = cv[N];

  for (genvar i = 0; i < N; i++) begin : g_bit
    if (i == 0 || i == K) begin : g_one
      // constant bit of T is one: full adder with third input tied high
      assign h[i]    = ~(a_i[i] ^ b_i[i]);
      assign cv[i+1] = a_i[i] | b_i[i];
    end else begin : g_zero
      assign h[i]    = a_i[i] ^ b_i[i];
      assign cv[i+1] = a_i[i] & b_i[i];
    end
    assign g_o[i] = h[i] & cv[i];
    assign q_o[i] = h[i] ^ cv[i];
  end
endmodule

// File: rtl/modadd_sklansky.sv
module modadd_sklansky #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] g_i,
  input  logic [W-1:0] p_i,
  output logic [W-1:0] g_o,
  output logic [W-1:0] p_o
);
  import modadd_pkg::*;
  localparam int unsigned LV = $clog2(W);

  logic [W-1:0] gl [LV+1];
  logic [W-1:0] pl [LV+1];

  assign gl[0] = g_i;
  assign pl[0] = p_i;

  for (genvar l = 0; l < LV; l++) begin : g_lvl
    for (genvar i = 0; i < W; i++) begin : g_node
      if (((i >> l) & 1) == 1) begin : g_op
        localparam int J = ((i >> l) << l) - 1;
        assign {gl[l+1][i], pl[l+1][i]} = gp_merge(gl[l][i], pl[l][i], gl[l][J], pl[l][J]);
      end else begin : g_pass
        assign gl[l+1][i] = gl[l][i];
        assign pl[l+1][i] = pl[l][i];
      end
    end
  end

  assign g_o = gl[LV];
  assign p_o = pl[LV];
endmodule

// File: rtl/modadd_carry.sv
module modadd_carry #(
  parameter int unsigned N = 8,
  parameter int unsigned K = 4
) (
  input  logic [N-1:0] g_i,
  input  logic [N-1:0] q_i,
  output logic [N:0]   kt_o   // kt_o[i]: carry into bit i of A+B+T, kt_o[N]: prefix carry-out
);
  localparam int unsigned WH = N - K;

  logic [K-1:0]  gl, pl;
  logic [WH-1:0] gh, ph;
  logic          clo;

  modadd_sklansky #(.W(K)) u_lo (
    .g_i(g_i[K-1:0]), .p_i(q_i[K-1:0]), .g_o(gl), .p_o(pl)
  );

  modadd_sklansky #(.W(WH)) u_hi (
    .g_i(g_i[N-1:K]), .p_i(q_i[N-1:K]), .g_o(gh), .p_o(ph)
  );

  assign clo     = gl[K-1];
  assign kt_o[0] = 1'b0;

  for (genvar i = 0; i < K; i++) begin : g_lo_c
    assign kt_o[i+1] = gl[i];
  end

  for (genvar j = 0; j < WH; j++) begin : g_hi_c
    assign kt_o[K+1+j] = gh[j] | (ph[j] & clo);
  end
endmodule

// File: rtl/modadd_fix.sv
module modadd_fix #(
  parameter int unsigned N = 8,
  parameter int unsigned K = 4
) (
  input  logic [N-1:0] q_i,
  input  logic [N-1:0] p_i,
  input  logic [N:0]   kt_i,
  input  logic         cn_i,
  output logic [N-1:0] r_o,
  output logic         sel_o
);
  logic [N-1:0] y, z, w, cp;
  logic [N:0]   bw1, bw2;

  assign y     = q_i ^ kt_i[N-1:0];
  assign sel_o = cn_i | kt_i[N];

  // first correction: remove the one at bit 0
  always_comb begin
    bw1[0] = 1'b1;
    for (int i = 0; i < N; i++) bw1[i+1] = bw1[i] & ~y[i];
    z = y ^ bw1[N-1:0];
  end

  // second correction: remove the one at bit K
  always_comb begin
    bw2 = '0;
    bw2[K] = 1'b1;
    for (int i = K; i < N; i++) bw2[i+1] = bw2[i] & ~z[i];
    for (int i = 0; i < N; i++) w[i] = (i >= K) ? (z[i] ^ bw2[i]) : z[i];
  end

  assign cp  = p_i ^ w;
  assign r_o = sel_o ? kt_i[N-1:0] : cp;
endmodule

// File: rtl/rns_mod_adder.sv
module rns_mod_adder #(
  parameter int unsigned N = 8,
  parameter int unsigned K = 4
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  output logic [N-1:0] sum_o
);
  logic [N-1:0] g, q, p, r;
  logic [N:0]   kt;
  logic         cn, sel;

  modadd_pre #(.N(N), .K(K)) u_pre (
    .a_i(a_i), .b_i(b_i), .g_o(g), .q_o(q), .p_o(p), .cn_o(cn)
  );

  modadd_carry #(.N(N), .K(K)) u_carry (
    .g_i(g), .q_i(q), .kt_o(kt)
  );

  modadd_fix #(.N(N), .K(K)) u_fix (
    .q_i(q), .p_i(p), .kt_i(kt), .cn_i(cn), .r_o(r), .sel_o(sel)
  );

  assign sum_o = sel ? (q ^ r) : (p ^ r);
endmodule

// File: rtl/rns_mod_adder_chk.sv
module rns_mod_adder_chk #(
  parameter int unsigned N = 8,
  parameter int unsigned K = 4
) (
  input logic [N-1:0] a_i,
  input logic [N-1:0] b_i,
  input logic [N-1:0] sum_o,
  input logic [N-1:0] q,
  input logic [N-1:0] p,
  input logic [N-1:0] r,
  input logic [N:0]   kt,
  input logic         sel
);
  localparam logic [N+1:0] M = (N+2)'((1 << N) - (1 << K) - 1);
  localparam logic [N+1:0] T = (N+2)'((1 << K) + 1);

  logic [N+1:0] ab, abt;
  logic         legal;

  assign ab    = {2'b00, a_i} + {2'b00, b_i};
  assign abt   = ab + T;
  assign legal = ({2'b00, a_i} < M) && ({2'b00, b_i} < M);

  always_comb begin
    if (legal) begin
      assert_range_R2: assert ({2'b00, sum_o} < M);
      if (ab < M) begin
        assert_nowrap_R3: assert ({2'b00, sum_o} == ab);
      end else begin
        assert_wrap_R4: assert ({2'b00, sum_o} == ab - M);
      end
      assert_tsum_R8: assert ({1'b0, sel, q ^ kt[N-1:0]} == abt);
      if (!sel) begin
        assert_plain_R9: assert ((p ^ r) == ab[N-1:0]);
      end
    end
  end
endmodule

bind rns_mod_adder rns_mod_adder_chk #(.N(N), .K(K)) u_chk (
  .a_i(a_i), .b_i(b_i), .sum_o(sum_o), .q(q), .p(p), .r(r), .kt(kt), .sel(sel)
);

// File: tb/test_rns_mod_adder.sv
module test_rns_mod_adder;
  localparam int CLK_PERIOD = 10;
  localparam int N0 = 8;
  localparam int K0 = 4;
  localparam int M0 = (1 << N0) - (1 << K0) - 1;
  localparam int N1 = 11;
  localparam int K1 = 3;
  localparam int M1 = (1 << N1) - (1 << K1) - 1;
  localparam int WDOG = 150000;
  localparam int NVEC = 14;

  // {a, b, expected, requirement}
  localparam logic [31:0] VEC [NVEC] = '{
    {8'd0,   8'd0,   8'd0,   8'd3},  // R3
    {8'd1,   8'd2,   8'd3,   8'd3},  // R3
    {8'd0,   8'd238, 8'd238, 8'd5},  // R5
    {8'd100, 8'd138, 8'd238, 8'd5},  // R5
    {8'd100, 8'd139, 8'd0,   8'd5},  // R5
    {8'd238, 8'd1,   8'd0,   8'd5},  // R5
    {8'd238, 8'd238, 8'd237, 8'd4},  // R4
    {8'd200, 8'd100, 8'd61,  8'd4},  // R4
    {8'd128, 8'd128, 8'd17,  8'd4},  // R4
    {8'd127, 8'd127, 8'd15,  8'd4},  // R4
    {8'd16,  8'd223, 8'd0,   8'd8},  // R8
    {8'd17,  8'd223, 8'd1,   8'd8},  // R8
    {8'd16,  8'd222, 8'd238, 8'd9},  // R9
    {8'd15,  8'd15,  8'd30,  8'd9}   // R9
  };

  logic clk = 1'b0;
  logic [N0-1:0] a0 = '0, b0 = '0, s0;
  logic [N1-1:0] a1 = '0, b1 = '0, s1;
  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rns_mod_adder #(.N(N0), .K(K0)) i_rns_mod_adder (.a_i(a0), .b_i(b0), .sum_o(s0));
  rns_mod_adder #(.N(N1), .K(K1)) i_rns_mod_adder_alt (.a_i(a1), .b_i(b1), .sum_o(s1));

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic apply0(input int x, input int y);
    @(posedge clk);
    #1 a0 = N0'(x); b0 = N0'(y);
    #2;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > WDOG) begin
        checks++;
        fails++;
        $display("FAIL R1 watchdog got=%0d exp=%0d", cyc, WDOG);
        finish_run();
      end
    end
  end

  initial begin
    int sw;
    // initial output with zero operands, R3
    #3;
    check("R3 initial", int'(s0), 0);

    // directed table
    for (int v = 0; v < NVEC; v++) begin
      apply0(int'(VEC[v][31:24]), int'(VEC[v][23:16]));
      check($sformatf("R%0d a=%0d b=%0d", VEC[v][7:0], VEC[v][31:24], VEC[v][23:16]),
            int'(s0), int'(VEC[v][15:8]));
    end

    // operand swap, R6
    for (int v = 0; v < NVEC; v++) begin
      apply0(int'(VEC[v][23:16]), int'(VEC[v][31:24]));
      check("R6 swapped", int'(s0), int'(VEC[v][15:8]));
    end
    apply0(5, 233);
    sw = int'(s0);
    apply0(233, 5);
    check("R6 5/233", int'(s0), sw);

    // exhaustive sweep, R1 and R2
    for (int x = 0; x < M0; x++) begin
      for (int y = 0; y < M0; y++) begin
        apply0(x, y);
        check($sformatf("R1 a=%0d b=%0d", x, y), int'(s0), (x + y) % M0);
        if (int'(s0) >= M0) check("R2 range", int'(s0), M0 - 1);
      end
    end

    // second size, R7
    a1 = N1'(M1 - 1); b1 = N1'(M1 - 1);
    #3 check("R7 max pair", int'(s1), M1 - 2);
    a1 = N1'(M1 - 8); b1 = N1'(8);
    #3 check("R7 wrap to zero", int'(s1), 0);
    for (int t = 0; t < 3000; t++) begin
      int x, y;
      x = int'($urandom_range(M1 - 1));
      y = int'($urandom_range(M1 - 1));
      @(posedge clk);
      #1 a1 = N1'(x); b1 = N1'(y);
      #2 check($sformatf("R7 a=%0d b=%0d", x, y), int'(s1), (x + y) % M1);
    end

    finish_run();
  end
endmodule